// File: doc/BRIEF.md
# Crosspoint Switch Configuration Target (I2C, write-only)

This block is the control front end of a 12-input, 9-output analog switch matrix. It listens on a two-wire I2C-compatible bus and acts as a write-only target. The block oversamples SCL and SDA with the system clock and finds START and STOP conditions itself. Each write transaction is three bytes long: a device address byte, an internal register address byte and one data byte. Matching bytes are acknowledged by pulling SDA low.

Nine per-output registers hold an enable, a gain step and an input-select code. Two more registers hold one clamp/bias bit per input. From these registers the block drives the matrix controls directly. Each output gets an enable, a high-impedance indication, a 2-bit gain code and a one-hot select vector. The inputs share one 12-bit clamp/bias vector. A strap pin sets the top bit of the device address, so two matrices can share one bus. Because a powered-down output releases its pin, several matrices can also be wired in parallel to form a larger switch.

Top module: `xbar_ctl_i2c`

## Requirements
- R1: After reset every output is disabled (`out_en` 0, `out_hiz` 1), every gain code is 00, every select vector is all zeros, `clamp_sel` is all zeros (bias), and `sda_oe` is 0.
- R2: With `addr_strap` low, only the address byte 0x06 is acknowledged. With `addr_strap` high, only 0x86 is acknowledged. Any other address byte gets no acknowledge, and the block then ignores the bus until the next START.
- R3: An address byte with bit 0 set (a read request) is never acknowledged. No register changes as a result.
- R4: After an acknowledged address byte, the next byte is taken as the internal register address and the byte after it as the data. Both bytes are acknowledged. The register changes only after the acknowledge clock of the data byte has ended.
- R5: Internal addresses 0x01 to 0x09 are the registers of outputs 1 to 9. Within each register, bit 7 is the enable, bits 6:5 drive `out_gain[2*i+1:2*i]` and bits 4:0 are the select code.
- R6: The select vector of output i is `out_sel[12*i+11:12*i]`. Select code k (1 to 12) sets only bit k-1 of that vector. Codes 0 and 13 to 31 give an all-zero vector.
- R7: While an output's enable bit is 0, its select vector is all zeros and its `out_hiz` is 1, whatever select code it holds. The stored code reappears once the output is enabled again.
- R8: Several outputs may select the same input at the same time, and each of them shows that input's bit.
- R9: Bits 7:0 of address 0x1D set `clamp_sel[7:0]`, and bits 3:0 of address 0x1E set `clamp_sel[11:8]`. Bits 7:4 of 0x1E are ignored. A 1 selects clamp and a 0 selects bias.
- R10: A write to any other internal address is acknowledged and changes no output.
- R11: If a STOP or a repeated START arrives before a data byte is complete, that byte is dropped and the registers keep their values. A repeated START begins a new transaction.
- R12: `sda_oe` is 1 only during acknowledge bits. It rises while SCL is low and is 0 whenever the master is sending data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_strap | input | 1 | Strap pin; when high it sets bit 7 of the device address byte |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, read as seen on the wire |
| sda_oe | output | 1 | When 1, the open-drain driver pulls SDA low (acknowledge) |
| out_en | output | 9 | Per-output enable |
| out_hiz | output | 9 | Per-output high-impedance indication (powered down) |
| out_gain | output | 18 | Per-output 2-bit gain code, output i at bits 2i+1:2i |
| out_sel | output | 108 | Per-output one-hot input select, output i at bits 12i+11:12i |
| clamp_sel | output | 12 | Per-input clamp (1) or bias (0) |

## Verification
The routing function is driven with a mix of select codes, and each one separates a different kind of fault:
- Codes at the ends of the valid range (1 and 12) expose off-by-one faults in the one-hot decode.
- Codes just past the range (13, 31) expose a decoder that wraps instead of clearing the vector.
- Zero with the enable set checks that "no input" really gives an empty vector.
- Two outputs on the same input check that outputs do not exclude each other.
- A disabled output that holds a valid code checks that the enable gate sits in front of the select vector.

The bus side is driven with patterns that change one thing at a time: matching addresses, non-matching addresses, read requests, strap flips, undefined internal addresses, and transfers cut off by STOP or repeated START. Comparing these cases shows whether address matching, acknowledge generation and the commit point each behave on their own. A behavioural model of the register file is compared with every output on every clock.

// File: rtl/xbar_ctl_pkg.sv
// Package: shared widths, the output-register layout and the receiver
// state types used by the crosspoint configuration target.
package xbar_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int GAIN_W = 2;
    localparam int SEL_W  = 5;

    // Layout of one output control register (bit 7 down to bit 0).
    typedef struct packed {
        logic              en;
        logic [GAIN_W-1:0] gain;
        logic [SEL_W-1:0]  sel;
    } out_cfg_t;

    // Receiver states: idle, shifting a byte, driving an acknowledge.
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_BYTE = 2'd1,
        RX_ACK  = 2'd2
    } rx_state_t;

    // Which byte of the transaction is being received.
    typedef enum logic [1:0] {
        PH_DEV  = 2'd0,
        PH_REG  = 2'd1,
        PH_DATA = 2'd2
    } rx_phase_t;

endpackage

// File: rtl/xbar_ctl_pin_sync.sv
// Module: xbar_ctl_pin_sync
// Brings SCL and SDA into the clock domain through a flop chain and flags
// SCL edges and START/STOP conditions for one cycle each.
// Assumes: the system clock is fast enough that every bus phase lasts
// several clock periods. SYNC_STAGES must be at least 2.
module xbar_ctl_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_lvl;

    // Synchronizer chains plus the one-cycle history used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl = sda_pipe[SYNC_STAGES-1];

    // Edge and condition flags derived from the synchronized lines.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/xbar_ctl_rx.sv
// Module: xbar_ctl_rx
// Write-only bus target: shifts in the address, register and data bytes,
// acknowledges them and issues a single write strobe once the data byte's
// acknowledge clock has ended.
// Assumes: inputs come from xbar_ctl_pin_sync. The master changes SDA only
// while SCL is low, except for START and STOP.
module xbar_ctl_rx
    import xbar_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strap,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    rx_state_t         state;
    rx_phase_t         phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] dev_expect;
    logic              byte_ok;

    // Device address byte expected, with the strap setting the top bit.
    always_comb begin
        dev_expect = DEV_ADDR | {addr_strap, {(BYTE_W-1){1'b0}}};
        byte_ok    = (phase != PH_DEV) || (shreg == dev_expect);
    end

    // Bus protocol state machine with byte shifting and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            phase   <= PH_DEV;
            bit_cnt <= '0;
            shreg   <= '0;
            addr_q  <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state   <= RX_BYTE;
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= RX_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    RX_BYTE: begin
                        if (scl_rise && bit_cnt != FULL_CNT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL_CNT) begin
                            if (byte_ok) begin
                                sda_oe <= 1'b1;
                                state  <= RX_ACK;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            case (phase)
                                PH_DEV: begin
                                    phase <= PH_REG;
                                    state <= RX_BYTE;
                                end
                                PH_REG: begin
                                    addr_q <= shreg;
                                    phase  <= PH_DATA;
                                    state  <= RX_BYTE;
                                end
                                default: begin
                                    wr_stb  <= 1'b1;
                                    wr_addr <= addr_q;
                                    wr_data <= shreg;
                                    state   <= RX_IDLE;
                                end
                            endcase
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/xbar_ctl_regs.sv
// Module: xbar_ctl_regs
// Register file: one control register per output at consecutive addresses
// from OUT_BASE, and packed clamp/bias bits (eight inputs per address) from
// CLAMP_BASE. Writes to any other address are dropped.
// Assumes: wr_stb is a one-cycle pulse with wr_addr and wr_data valid.
module xbar_ctl_regs
    import xbar_ctl_pkg::*;
#(
    parameter int                N_IN       = 12,
    parameter int                N_OUT      = 9,
    parameter logic [BYTE_W-1:0] OUT_BASE   = 8'h01,
    parameter logic [BYTE_W-1:0] CLAMP_BASE = 8'h1D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [BYTE_W-1:0]       wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [N_OUT*BYTE_W-1:0] cfg_flat,
    output logic [N_IN-1:0]         clamp_sel
);

    genvar o, j;

    generate
        for (o = 0; o < N_OUT; o++) begin : g_out
            localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(OUT_BASE + o);
            out_cfg_t cfg_q;
            // Output register: loaded as a whole when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= '0;
                end else if (wr_stb && wr_addr == MY_ADDR) begin
                    cfg_q <= wr_data;
                end
            end
            assign cfg_flat[o*BYTE_W +: BYTE_W] = cfg_q;
        end

        for (j = 0; j < N_IN; j++) begin : g_clamp
            localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(CLAMP_BASE + j / BYTE_W);
            localparam int                MY_BIT  = j % BYTE_W;
            // Clamp/bias bit: takes its data bit when its packed address is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    clamp_sel[j] <= 1'b0;
                end else if (wr_stb && wr_addr == MY_ADDR) begin
                    clamp_sel[j] <= wr_data[MY_BIT];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xbar_ctl_route_dec.sv
// Module: xbar_ctl_route_dec
// Turns each output register into its enable, high-impedance flag, gain
// code and a one-hot input select. The select is gated off while the
// output is disabled, and codes beyond N_IN give an empty vector.
// Assumes: N_IN is below 2**SEL_W.
module xbar_ctl_route_dec
    import xbar_ctl_pkg::*;
#(
    parameter int N_IN  = 12,
    parameter int N_OUT = 9
) (
    input  logic [N_OUT*BYTE_W-1:0] cfg_flat,
    output logic [N_OUT-1:0]        out_en,
    output logic [N_OUT-1:0]        out_hiz,
    output logic [N_OUT*GAIN_W-1:0] out_gain,
    output logic [N_OUT*N_IN-1:0]   out_sel
);

    genvar o, k;

    generate
        for (o = 0; o < N_OUT; o++) begin : g_out
            out_cfg_t cfg_o;
            assign cfg_o = cfg_flat[o*BYTE_W +: BYTE_W];
            // Per-output control levels.
            always_comb begin
                out_en[o]                  = cfg_o.en;
                out_hiz[o]                 = ~cfg_o.en;
                out_gain[o*GAIN_W +: GAIN_W] = cfg_o.gain;
            end
            for (k = 0; k < N_IN; k++) begin : g_in
                localparam logic [SEL_W-1:0] CODE = SEL_W'(k + 1);
                // One select line: set when enabled and the code names this input.
                assign out_sel[o*N_IN + k] = cfg_o.en && (cfg_o.sel == CODE);
            end
        end
    endgenerate

endmodule

// File: rtl/xbar_ctl_i2c.sv
// Module: xbar_ctl_i2c (top)
// Write-only configuration target for an N_IN x N_OUT crosspoint. Chains
// the line synchronizer, the bus receiver, the register file and the route
// decoder.
// Assumes: sda_oe controls an external open-drain pull-down on SDA, and
// sda_i reads the wired line.
module xbar_ctl_i2c
    import xbar_ctl_pkg::*;
#(
    parameter int                N_IN        = 12,
    parameter int                N_OUT       = 9,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'h06,
    parameter logic [BYTE_W-1:0] OUT_BASE    = 8'h01,
    parameter logic [BYTE_W-1:0] CLAMP_BASE  = 8'h1D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_strap,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    output logic [N_OUT-1:0]        out_en,
    output logic [N_OUT-1:0]        out_hiz,
    output logic [N_OUT*GAIN_W-1:0] out_gain,
    output logic [N_OUT*N_IN-1:0]   out_sel,
    output logic [N_IN-1:0]         clamp_sel
);

    logic                    sda_lvl;
    logic                    scl_rise;
    logic                    scl_fall;
    logic                    start_det;
    logic                    stop_det;
    logic                    wr_stb;
    logic [BYTE_W-1:0]       wr_addr;
    logic [BYTE_W-1:0]       wr_data;
    logic [N_OUT*BYTE_W-1:0] cfg_flat;

    xbar_ctl_pin_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    xbar_ctl_rx #(
        .DEV_ADDR(DEV_ADDR)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_strap(addr_strap),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    xbar_ctl_regs #(
        .N_IN      (N_IN),
        .N_OUT     (N_OUT),
        .OUT_BASE  (OUT_BASE),
        .CLAMP_BASE(CLAMP_BASE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_flat (cfg_flat),
        .clamp_sel(clamp_sel)
    );

    xbar_ctl_route_dec #(
        .N_IN (N_IN),
        .N_OUT(N_OUT)
    ) u_dec (
        .cfg_flat(cfg_flat),
        .out_en  (out_en),
        .out_hiz (out_hiz),
        .out_gain(out_gain),
        .out_sel (out_sel)
    );

endmodule

// File: rtl/xbar_ctl_i2c_chk.sv
// Module: xbar_ctl_i2c_chk
// Checker for the configuration target's ports, bound to every instance.
module xbar_ctl_i2c_chk #(
    parameter int N_IN   = 12,
    parameter int N_OUT  = 9,
    parameter int GAIN_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_i,
    input logic                    sda_oe,
    input logic [N_OUT-1:0]        out_en,
    input logic [N_OUT-1:0]        out_hiz,
    input logic [N_OUT*GAIN_W-1:0] out_gain,
    input logic [N_OUT*N_IN-1:0]   out_sel,
    input logic [N_IN-1:0]         clamp_sel
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_en == '0 && out_sel == '0 && out_gain == '0 && clamp_sel == '0 && !sda_oe)); // R1

    AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({out_en, out_gain, out_sel, clamp_sel}) |-> $past(sda_oe, 2)); // R4

    AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R12

    genvar o;
    generate
        for (o = 0; o < N_OUT; o++) begin : g_out
            AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(out_sel[o*N_IN +: N_IN])); // R6

            AST_OFF_SELECTS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
                out_hiz[o] |-> (out_sel[o*N_IN +: N_IN] == '0)); // R7
        end
    endgenerate

endmodule

bind xbar_ctl_i2c xbar_ctl_i2c_chk #(
    .N_IN (N_IN),
    .N_OUT(N_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .out_en   (out_en),
    .out_hiz  (out_hiz),
    .out_gain (out_gain),
    .out_sel  (out_sel),
    .clamp_sel(clamp_sel)
);

// File: tb/tb_xbar_ctl_i2c.sv
module tb_xbar_ctl_i2c;

    localparam int NI = 12;
    localparam int NO = 9;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_strap = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [NO-1:0]    out_en;
    logic [NO-1:0]    out_hiz;
    logic [NO*2-1:0]  out_gain;
    logic [NO*NI-1:0] out_sel;
    logic [NI-1:0]    clamp_sel;

    int checks = 0;
    int errors = 0;
    int mon_err = 0;
    int oe_viol = 0;
    bit hold_cmp = 1'b0;
    bit done = 1'b0;

    int m_en[NO];
    int m_gain[NO];
    int m_code[NO];
    logic [NI-1:0] m_clamp;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    xbar_ctl_i2c dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_strap(addr_strap),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .out_en    (out_en),
        .out_hiz   (out_hiz),
        .out_gain  (out_gain),
        .out_sel   (out_sel),
        .clamp_sel (clamp_sel)
    );

    function automatic logic [NI-1:0] exp_sel(input int o);
        logic [NI-1:0] v = '0;
        if (m_en[o] != 0 && m_code[o] >= 1 && m_code[o] <= NI) v[m_code[o]-1] = 1'b1;
        return v;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h01 && a <= 8'h09) begin
            m_en[a-1]   = int'(d[7]);
            m_gain[a-1] = int'(d[6:5]);
            m_code[a-1] = int'(d[4:0]);
        end else if (a == 8'h1D) begin
            m_clamp[7:0] = d;
        end else if (a == 8'h1E) begin
            m_clamp[11:8] = d[3:0];
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of every output against the behavioural model (R5..R9).
    always @(negedge clk) begin
        if (rst_n && !hold_cmp && !done) begin
            for (int o = 0; o < NO; o++) begin
                if (out_en[o] !== (m_en[o] != 0) || out_hiz[o] !== (m_en[o] == 0) ||
                    out_gain[2*o +: 2] !== 2'(m_gain[o]) || out_sel[o*NI +: NI] !== exp_sel(o)) begin
                    mon_err++;
                    if (mon_err <= 5)
                        $display("FAIL R5 monitor output %0d actual en=%0b sel=%0h expected en=%0d sel=%0h",
                                 o, out_en[o], out_sel[o*NI +: NI], m_en[o], exp_sel(o));
                end
            end
            if (clamp_sel !== m_clamp) begin
                mon_err++;
                if (mon_err <= 5) $display("FAIL R9 monitor clamp actual=%0h expected=%0h", clamp_sel, m_clamp);
            end
        end
    end

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(1);
        scl = 1'b1;   wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl = 1'b0;   wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl = 1'b1;   wait_q(1);
        sda_m = 1'b1; wait_q(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_q(1);
            scl = 1'b1;   wait_q(1);
            if (sda_oe) oe_viol++;
            wait_q(1);
            scl = 1'b0;   wait_q(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit is_data, input logic [7:0] ra, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q(1);
        scl = 1'b1;   wait_q(1);
        ack = !sda_bus;
        wait_q(1);
        if (is_data && ack) hold_cmp = 1'b1;
        scl = 1'b0;   wait_q(1);
        if (is_data && ack) begin
            model_write(ra, b);
            hold_cmp = 1'b0;
        end
    endtask

    // Full three-byte write; checks the acknowledge of each byte.
    task automatic wr_txn(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          input bit exp_ack, input string tag);
        bit a0, a1, a2;
        bus_start();
        send_byte(dev, 1'b0, 8'h00, a0);
        send_byte(ra, 1'b0, 8'h00, a1);
        send_byte(d, exp_ack, ra, a2);
        bus_stop();
        chk(a0 == exp_ack && a1 == exp_ack && a2 == exp_ack, tag, {a0, a1, a2}, {3{exp_ack}});
    endtask

    logic [NO*NI+NO*2+NO+NI-1:0] snap;

    initial begin
        for (int o = 0; o < NO; o++) begin m_en[o] = 0; m_gain[o] = 0; m_code[o] = 0; end
        m_clamp = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset defaults
        chk(out_en == '0 && out_hiz == '1, "R1 enable/hiz", {out_en, out_hiz}, {{NO{1'b0}}, {NO{1'b1}}});
        chk(out_gain == '0 && out_sel == '0 && clamp_sel == '0 && !sda_oe, "R1 gain/sel/clamp",
            {out_gain, clamp_sel, sda_oe}, '0);

        // R5 R6: field positions, lowest select code
        wr_txn(8'h06, 8'h01, 8'hA3, 1'b1, "R4 ack out1");
        chk(out_en[0] && out_gain[1:0] == 2'b01 && out_sel[11:0] == 12'h004, "R5 out1 fields",
            {out_en[0], out_gain[1:0], out_sel[11:0]}, {1'b1, 2'b01, 12'h004});
        wr_txn(8'h06, 8'h09, 8'hEC, 1'b1, "R4 ack out9");
        chk(out_gain[17:16] == 2'b11 && out_sel[8*NI +: NI] == 12'h800, "R6 code 12 on out9",
            {out_gain[17:16], out_sel[8*NI +: NI]}, {2'b11, 12'h800});
        wr_txn(8'h06, 8'h05, 8'h81, 1'b1, "R4 ack out5");
        chk(out_sel[4*NI +: NI] == 12'h001, "R6 code 1", out_sel[4*NI +: NI], 12'h001);

        // R8: shared input
        wr_txn(8'h06, 8'h02, 8'h83, 1'b1, "R4 ack out2");
        chk(out_sel[11:0] == 12'h004 && out_sel[23:12] == 12'h004, "R8 shared input",
            out_sel[23:0], 24'h004004);

        // R7: disabled output holding a valid code
        wr_txn(8'h06, 8'h03, 8'h45, 1'b1, "R4 ack out3 off");
        chk(!out_en[2] && out_hiz[2] && out_sel[35:24] == 12'h000, "R7 disabled gates select",
            {out_hiz[2], out_sel[35:24]}, {1'b1, 12'h000});
        wr_txn(8'h06, 8'h03, 8'hC5, 1'b1, "R4 ack out3 on");
        chk(out_sel[35:24] == 12'h010 && !out_hiz[2], "R7 re-enabled", out_sel[35:24], 12'h010);

        // R6: out-of-range and zero codes
        wr_txn(8'h06, 8'h04, 8'h8D, 1'b1, "R4 ack out4");
        chk(out_en[3] && out_sel[47:36] == 12'h000, "R6 code 13", out_sel[47:36], 12'h000);
        wr_txn(8'h06, 8'h04, 8'h9F, 1'b1, "R4 ack out4");
        chk(out_sel[47:36] == 12'h000, "R6 code 31", out_sel[47:36], 12'h000);
        wr_txn(8'h06, 8'h04, 8'h80, 1'b1, "R4 ack out4");
        chk(out_en[3] && out_sel[47:36] == 12'h000, "R6 code 0", out_sel[47:36], 12'h000);

        // R9: clamp registers, reserved bits ignored
        wr_txn(8'h06, 8'h1D, 8'hA5, 1'b1, "R4 ack clamp lo");
        wr_txn(8'h06, 8'h1E, 8'hF6, 1'b1, "R4 ack clamp hi");
        chk(clamp_sel == 12'h6A5, "R9 clamp vector", clamp_sel, 12'h6A5);

        // R10: undefined addresses acknowledged, nothing changes
        snap = {out_sel, out_gain, out_en, clamp_sel};
        wr_txn(8'h06, 8'h00, 8'hFF, 1'b1, "R10 ack addr 00");
        wr_txn(8'h06, 8'h0A, 8'hFF, 1'b1, "R10 ack addr 0A");
        wr_txn(8'h06, 8'h1C, 8'hFF, 1'b1, "R10 ack addr 1C");
        wr_txn(8'h06, 8'h1F, 8'hFF, 1'b1, "R10 ack addr 1F");
        wr_txn(8'h06, 8'hFF, 8'h00, 1'b1, "R10 ack addr FF");
        chk(snap == {out_sel, out_gain, out_en, clamp_sel}, "R10 no effect",
            {out_sel, out_gain, out_en, clamp_sel}, snap);

        // R2: address matching and strap
        wr_txn(8'h08, 8'h01, 8'h00, 1'b0, "R2 wrong address nack");
        wr_txn(8'h86, 8'h01, 8'h00, 1'b0, "R2 0x86 nack with strap low");
        chk(snap == {out_sel, out_gain, out_en, clamp_sel}, "R2 no effect",
            {out_sel, out_gain, out_en, clamp_sel}, snap);
        addr_strap = 1'b1;
        wr_txn(8'h06, 8'h01, 8'h00, 1'b0, "R2 0x06 nack with strap high");
        wr_txn(8'h86, 8'h06, 8'hA7, 1'b1, "R2 0x86 ack with strap high");
        chk(out_sel[5*NI +: NI] == 12'h040 && out_gain[11:10] == 2'b01, "R2 strap write",
            out_sel[5*NI +: NI], 12'h040);
        addr_strap = 1'b0;

        // R3: read request
        snap = {out_sel, out_gain, out_en, clamp_sel};
        wr_txn(8'h07, 8'h01, 8'h00, 1'b0, "R3 read nack");
        chk(snap == {out_sel, out_gain, out_en, clamp_sel}, "R3 no effect",
            {out_sel, out_gain, out_en, clamp_sel}, snap);

        // R11: STOP mid data byte
        begin
            bit a;
            bus_start();
            send_byte(8'h06, 1'b0, 8'h00, a);
            send_byte(8'h07, 1'b0, 8'h00, a);
            send_bits(8'h8B, 4);
            bus_stop();
            chk(out_en[6] == 1'b0 && out_sel[6*NI +: NI] == 12'h000, "R11 stop abandons",
                {out_en[6], out_sel[6*NI +: NI]}, 13'h0);
            // R11: repeated START mid data byte, then a fresh transaction
            bus_start();
            send_byte(8'h06, 1'b0, 8'h00, a);
            send_byte(8'h07, 1'b0, 8'h00, a);
            send_bits(8'h8B, 3);
            bus_start();
            send_byte(8'h06, 1'b0, 8'h00, a);
            chk(a, "R11 repeated start address ack", a, 1'b1);
            send_byte(8'h08, 1'b0, 8'h00, a);
            send_byte(8'h8A, 1'b1, 8'h08, a);
            bus_stop();
            chk(out_en[6] == 1'b0 && out_sel[7*NI +: NI] == 12'h200, "R11 only new write lands",
                {out_en[6], out_sel[7*NI +: NI]}, {1'b0, 12'h200});
        end

        // R12: acknowledge drive confined to ack bits
        chk(!sda_oe, "R12 released after stop", sda_oe, 1'b0);
        chk(oe_viol == 0, "R12 no drive during data bits", oe_viol, 0);
        chk(mon_err == 0, "R5 per-clock model compare", mon_err, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule